// File: doc/BRIEF.md
# SDRAM Command Legality Checker

This block watches the command pins of a two-bank, single-data-rate SDRAM on every rising clock edge. It turns the pin pattern into a command code and keeps its own model of each bank. A bank is idle, has an open row, is running a burst that closes itself with auto precharge, or is recovering after such a burst. Whenever a command would break the device's rules in the current state, the block raises an error in that same cycle and gives a code that names the rule.

The checker is passive. It is placed beside a memory controller, either in simulation or in silicon, to catch protocol errors. Burst length and the row-precharge recovery time are inputs, so one instance can follow whichever mode the controller has programmed. A command that raises an error is treated as if it had not been issued, and bank state stays as it was. Timers that are already running keep counting.

Top module: `sdcmd_checker`

## Requirements
- R1: With `cke_prev` high and `cs_n` low, the pin pattern {ras_n,cas_n,we_n} decodes onto `cmd_code` as follows: 000 is mode set (1), 001 is refresh (2) when `cke` is high or self-refresh entry (3) when `cke` is low, 011 is activate (4), 101 is read (5), 100 is write (6), 110 is burst stop (7), 010 is precharge (8), and 111 is no-op (0).
- R2: If `cs_n` is high or `cke_prev` is low, the cycle decodes as no-op (0). A no-op never raises an error and never changes bank state.
- R3: Bank state codes are 0 for idle, 1 for row open, 2 for auto-precharge burst and 3 for recovery. `ba` low selects bank A and `ba` high selects bank B. A legal activate moves the selected idle bank to state 1.
- R4: A legal precharge with `a10` high returns every bank in state 1 to idle. With `a10` low it returns only the selected bank. Banks in state 2 or 3 are not affected.
- R5: In the cycle after an accepted mode set, any command other than no-op gets error code 1.
- R6: Mode set, refresh or self-refresh entry while any bank is not idle gets error code 2.
- R7: A read or write issued while any bank is in state 2 gets error code 3.
- R8: Any other read or write to a bank that is not in state 1 gets error code 4.
- R9: An activate to a bank in state 1 or 2 gets error code 5. An activate to a bank in state 3 gets error code 6.
- R10: A legal read or write with `a10` high puts the bank in state 2 for the `burst_len`-1 cycles after the command, then in state 3 for `trp` cycles, then back to idle. With `burst_len` of 1 the bank skips state 2. With `trp` of 0 the bank skips state 3. A burst stop is never an error by itself, and it moves a bank that is in state 2 to state 3 (or to idle when `trp` is 0) on the next cycle.
- R11: A read or write with `a10` low to an open bank is legal and leaves the bank in state 1.
- R12: A command that raises an error changes no bank state. When several rules are broken at once, the lowest error code wins.
- R13: While `rst` is high at a clock edge, both banks go to idle and the mode-set gap is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_prev | input | 1 | Clock enable as sampled in the previous cycle |
| cke | input | 1 | Clock enable in the current cycle |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 1 | Bank select |
| a10 | input | 1 | All-bank or auto-precharge flag |
| burst_len | input | BL_W | Burst length in cycles, at least 1 |
| trp | input | TRP_W | Recovery cycles after an auto-precharge burst |
| cmd_code | output | 4 | Decoded command |
| err | output | 1 | Current command is illegal |
| err_code | output | 3 | Rule broken (0 means none) |
| bank_a_state | output | 2 | State of bank A |
| bank_b_state | output | 2 | State of bank B |

## Verification
The bench targets the one-cycle gap after a mode set: a design that counts the gap one cycle short would let a refresh through. It also targets the boundary where a bank leaves auto-precharge recovery. An activate issued one cycle early must report code 6, and one issued on time must be accepted; an off-by-one timer flips one of those two results. A read to the other bank during an auto-precharge burst breaks two rules at once, so wrong priority shows up as code 4 instead of 3. The bench also issues a burst stop partway through a burst, sets `burst_len` to 1 and `trp` to 0, and holds a full mode-set pattern under a deselect. A decoder that does not honour deselect would report an error or change state in that last case.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_MODE = 4'd1,
    CMD_REF  = 4'd2,
    CMD_SELF = 4'd3,
    CMD_ACT  = 4'd4,
    CMD_RD   = 4'd5,
    CMD_WR   = 4'd6,
    CMD_STOP = 4'd7,
    CMD_PRE  = 4'd8
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE    = 2'd0,
    BK_OPEN    = 2'd1,
    BK_APBURST = 2'd2,
    BK_RECOVER = 2'd3
  } bank_e;

  typedef enum logic [2:0] {
    ERR_NONE     = 3'd0,
    ERR_MODE_GAP = 3'd1,
    ERR_BUSY     = 3'd2,
    ERR_AP_LOCK  = 3'd3,
    ERR_CLOSED   = 3'd4,
    ERR_OPEN     = 3'd5,
    ERR_TRP      = 3'd6
  } err_e;

  // Number of burst cycles still ahead once the command cycle is done
  function automatic int unsigned burst_tail(input int unsigned len);
    return (len > 0) ? len - 1 : 0;
  endfunction

  // True when a command kind is a column access
  function automatic logic is_column(input cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  // True when a command kind needs every bank idle
  function automatic logic needs_all_idle(input cmd_e c);
    return (c == CMD_MODE) || (c == CMD_REF) || (c == CMD_SELF);
  endfunction

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  logic selected;
  assign selected = cke_prev && !cs_n;

  always_comb begin
    cmd = CMD_NOP;
    if (selected) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MODE;
        3'b001:  cmd = cke ? CMD_REF : CMD_SELF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b110:  cmd = CMD_STOP;
        3'b010:  cmd = CMD_PRE;
        default: cmd = CMD_NOP;
      endcase
    end
  end
endmodule

// File: rtl/sdcmd_rules.sv
module sdcmd_rules
  import sdcmd_pkg::*;
(
  input  cmd_e  cmd,
  input  logic  ba,
  input  logic  mode_gap,
  input  bank_e st_a,
  input  bank_e st_b,
  output err_e  code
);
  bank_e st_sel;
  logic  any_busy;
  logic  any_burst;

  assign st_sel    = ba ? st_b : st_a;
  assign any_busy  = (st_a != BK_IDLE) || (st_b != BK_IDLE);
  assign any_burst = (st_a == BK_APBURST) || (st_b == BK_APBURST);

  // Rules are tested in priority order: the first broken one sets the code
  always_comb begin
    code = ERR_NONE;
    if (cmd != CMD_NOP) begin
      if (mode_gap) begin
        code = ERR_MODE_GAP;
      end else if (needs_all_idle(cmd)) begin
        if (any_busy) code = ERR_BUSY;
      end else if (is_column(cmd)) begin
        if (any_burst)              code = ERR_AP_LOCK;
        else if (st_sel != BK_OPEN) code = ERR_CLOSED;
      end else if (cmd == CMD_ACT) begin
        if (st_sel == BK_RECOVER)   code = ERR_TRP;
        else if (st_sel != BK_IDLE) code = ERR_OPEN;
      end
    end
  end
endmodule

// File: rtl/sdcmd_bank.sv
module sdcmd_bank
  import sdcmd_pkg::*;
#(
  parameter int BL_W  = 4,
  parameter int TRP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BL_W-1:0]  burst_len,
  input  logic [TRP_W-1:0] trp,
  input  logic             go_act,
  input  logic             go_ap,
  input  logic             go_pre,
  input  logic             go_stop,
  output bank_e            state
);
  localparam int CNT_W = (BL_W > TRP_W) ? BL_W : TRP_W;

  logic [CNT_W-1:0] cnt;
  logic             burst_last;   // last cycle of an auto-precharge burst
  logic             short_burst;  // burst that is over in its command cycle
  logic             no_recover;   // recovery time of zero

  assign short_burst = burst_len <= BL_W'(1);
  assign no_recover  = trp == '0;
  assign burst_last  = (state == BK_APBURST) && (go_stop || cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= BK_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        BK_IDLE: if (go_act) state <= BK_OPEN;
        BK_OPEN: begin
          if (go_pre) begin
            state <= BK_IDLE;
          end else if (go_ap) begin
            if (!short_burst) begin
              state <= BK_APBURST;
              cnt   <= CNT_W'(burst_tail(int'(burst_len)));
            end else if (no_recover) begin
              state <= BK_IDLE;
            end else begin
              state <= BK_RECOVER;
              cnt   <= CNT_W'(trp);
            end
          end
        end
        BK_APBURST: begin
          if (burst_last) begin
            state <= no_recover ? BK_IDLE : BK_RECOVER;
            cnt   <= CNT_W'(trp);
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        BK_RECOVER: begin
          if (cnt <= CNT_W'(1)) state <= BK_IDLE;
          else                  cnt   <= cnt - CNT_W'(1);
        end
        default: state <= BK_IDLE;
      endcase
    end
  end

  p_act_only_idle_r9: assert property (@(posedge clk) disable iff (rst)
    go_act |-> state == BK_IDLE);

  p_recover_exit_r10: assert property (@(posedge clk) disable iff (rst)
    state == BK_RECOVER |=> (state == BK_RECOVER || state == BK_IDLE));

  p_stop_ends_burst_r10: assert property (@(posedge clk) disable iff (rst)
    (state == BK_APBURST && go_stop) |=> (state == BK_RECOVER || state == BK_IDLE));
endmodule

// File: rtl/sdcmd_checker.sv
module sdcmd_checker
  import sdcmd_pkg::*;
#(
  parameter int BL_W    = 4,
  parameter int TRP_W   = 4,
  parameter int MRS_GAP = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cke_prev,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             ba,
  input  logic             a10,
  input  logic [BL_W-1:0]  burst_len,
  input  logic [TRP_W-1:0] trp,
  output logic [3:0]       cmd_code,
  output logic             err,
  output logic [2:0]       err_code,
  output logic [1:0]       bank_a_state,
  output logic [1:0]       bank_b_state
);
  localparam int NUM_BANKS = 2;
  localparam int GAP_W     = $clog2(MRS_GAP + 1);

  cmd_e            cmd;
  err_e            code;
  bank_e           st [NUM_BANKS];
  logic            accepted;
  logic            mode_gap;
  logic [GAP_W-1:0] gap_q;
  logic            mode_taken;
  logic [NUM_BANKS-1:0] go_act, go_ap, go_pre;
  logic            go_stop;

  sdcmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd)
  );

  sdcmd_rules u_rules (
    .cmd      (cmd),
    .ba       (ba),
    .mode_gap (mode_gap),
    .st_a     (st[0]),
    .st_b     (st[1]),
    .code     (code)
  );

  assign accepted   = (code == ERR_NONE);
  assign mode_taken = accepted && (cmd == CMD_MODE);
  assign go_stop    = accepted && (cmd == CMD_STOP);
  assign mode_gap   = gap_q != '0;

  always_ff @(posedge clk) begin
    if (rst)             gap_q <= '0;
    else if (mode_taken) gap_q <= GAP_W'(MRS_GAP - 1);
    else if (mode_gap)   gap_q <= gap_q - GAP_W'(1);
  end

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic hit;
    assign hit       = (ba == g[0]);
    assign go_act[g] = accepted && (cmd == CMD_ACT) && hit;
    assign go_ap[g]  = accepted && is_column(cmd) && a10 && hit;
    assign go_pre[g] = accepted && (cmd == CMD_PRE) && (a10 || hit);

    sdcmd_bank #(.BL_W(BL_W), .TRP_W(TRP_W)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .burst_len (burst_len),
      .trp       (trp),
      .go_act    (go_act[g]),
      .go_ap     (go_ap[g]),
      .go_pre    (go_pre[g]),
      .go_stop   (go_stop),
      .state     (st[g])
    );
  end

  assign cmd_code     = cmd;
  assign err          = !accepted;
  assign err_code     = code;
  assign bank_a_state = st[0];
  assign bank_b_state = st[1];

  p_mode_gap_r5: assert property (@(posedge clk) disable iff (rst)
    mode_taken |=> (cmd == CMD_NOP || err_code == ERR_MODE_GAP));

  p_nop_never_err_r2: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_NOP |-> !err);

  p_one_ap_burst_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st[0] == BK_APBURST, st[1] == BK_APBURST}));

  p_err_hold_idle_a_r12: assert property (@(posedge clk) disable iff (rst)
    (err && st[0] == BK_IDLE) |=> st[0] == BK_IDLE);

  p_err_hold_open_b_r12: assert property (@(posedge clk) disable iff (rst)
    (err && st[1] == BK_OPEN) |=> st[1] == BK_OPEN);
endmodule

// File: tb/tb_sdcmd_checker.sv
module tb_sdcmd_checker;
  localparam int GAP = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, cke_prev, cke, cs_n, ras_n, cas_n, we_n, ba, a10;
  logic [3:0] bl, tr;
  logic [3:0] cmd_code;
  logic       err;
  logic [2:0] err_code;
  logic [1:0] st_a, st_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int m_st[2];
  int m_left[2];
  int m_gap;

  sdcmd_checker #(.BL_W(4), .TRP_W(4), .MRS_GAP(GAP)) dut (
    .clk(clk), .rst(rst), .cke_prev(cke_prev), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .burst_len(bl), .trp(tr), .cmd_code(cmd_code), .err(err),
    .err_code(err_code), .bank_a_state(st_a), .bank_b_state(st_b)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int kind(bit cp, bit ck, bit cs, bit r, bit c, bit w);
    if (!cp || cs) return 0;
    if ({r, c, w} == 3'b000) return 1;
    if ({r, c, w} == 3'b001) return ck ? 2 : 3;
    if ({r, c, w} == 3'b011) return 4;
    if ({r, c, w} == 3'b101) return 5;
    if ({r, c, w} == 3'b100) return 6;
    if ({r, c, w} == 3'b110) return 7;
    if ({r, c, w} == 3'b010) return 8;
    return 0;
  endfunction

  task automatic cyc(bit cp, bit ck, bit cs, bit r, bit c, bit w, bit b, bit a, string req);
    int k;
    int e;
    bit ok;
    @(negedge clk);
    cke_prev = cp; cke = ck; cs_n = cs; ras_n = r; cas_n = c; we_n = w; ba = b; a10 = a;
    #1;
    k = kind(cp, ck, cs, r, c, w);
    e = 0;
    if (k != 0) begin
      if (m_gap > 0) e = 1;
      else if (k >= 1 && k <= 3) begin
        if (m_st[0] != 0 || m_st[1] != 0) e = 2;
      end else if (k == 5 || k == 6) begin
        if (m_st[0] == 2 || m_st[1] == 2) e = 3;
        else if (m_st[b] != 1) e = 4;
      end else if (k == 4) begin
        if (m_st[b] == 3) e = 6;
        else if (m_st[b] != 0) e = 5;
      end
    end
    check(req, "cmd_code", int'(cmd_code), k);
    check(req, "err_code", int'(err_code), e);
    check(req, "err", int'(err), (e != 0) ? 1 : 0);
    check(req, "bank_a_state", int'(st_a), m_st[0]);
    check(req, "bank_b_state", int'(st_b), m_st[1]);
    ok = (e == 0);
    for (int i = 0; i < 2; i++) begin
      bit hit;
      hit = (int'(b) == i);
      if (m_st[i] == 0) begin
        if (ok && k == 4 && hit) m_st[i] = 1;
      end else if (m_st[i] == 1) begin
        if (ok && k == 8 && (a || hit)) m_st[i] = 0;
        else if (ok && (k == 5 || k == 6) && a && hit) begin
          if (bl > 1) begin m_st[i] = 2; m_left[i] = int'(bl) - 1; end
          else if (tr == 0) m_st[i] = 0;
          else begin m_st[i] = 3; m_left[i] = int'(tr); end
        end
      end else if (m_st[i] == 2) begin
        if ((ok && k == 7) || m_left[i] == 1) begin
          if (tr == 0) m_st[i] = 0;
          else begin m_st[i] = 3; m_left[i] = int'(tr); end
        end else m_left[i]--;
      end else begin
        if (m_left[i] <= 1) m_st[i] = 0;
        else m_left[i]--;
      end
    end
    if (ok && k == 1) m_gap = GAP - 1;
    else if (m_gap > 0) m_gap--;
  endtask

  task automatic nop(string q);            cyc(1, 1, 0, 1, 1, 1, 0, 0, q); endtask
  task automatic act(bit b, string q);     cyc(1, 1, 0, 0, 1, 1, b, 0, q); endtask
  task automatic rd(bit b, bit ap, string q); cyc(1, 1, 0, 1, 0, 1, b, ap, q); endtask
  task automatic wr(bit b, bit ap, string q); cyc(1, 1, 0, 1, 0, 0, b, ap, q); endtask
  task automatic pre(bit b, bit all, string q); cyc(1, 1, 0, 0, 1, 0, b, all, q); endtask
  task automatic mode(string q);           cyc(1, 1, 0, 0, 0, 0, 0, 0, q); endtask
  task automatic refr(string q);           cyc(1, 1, 0, 0, 0, 1, 0, 0, q); endtask
  task automatic selfr(string q);          cyc(1, 0, 0, 0, 0, 1, 0, 0, q); endtask
  task automatic stop(string q);           cyc(1, 1, 0, 1, 1, 0, 0, 0, q); endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; cke_prev = 1; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
    ba = 0; a10 = 0; bl = 4'd4; tr = 4'd3;
    m_st[0] = 0; m_st[1] = 0; m_left[0] = 0; m_left[1] = 0; m_gap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    nop("R13");                 // reset leaves both banks idle
    mode("R6");                 // legal with all idle
    act(0, "R5");               // inside the mode-set gap: code 1
    refr("R5");                 // gap over: legal refresh
    mode("R5");
    refr("R5");                 // refresh in the gap: code 1
    act(0, "R3");
    mode("R6");                 // bank A open: code 2
    refr("R6");
    selfr("R6");
    rd(1, 0, "R8");             // bank B closed: code 4
    wr(0, 0, "R11");
    rd(0, 0, "R11");
    act(0, "R9");               // already open: code 5
    act(1, "R3");
    pre(1, 0, "R4");            // only B closes
    cyc(1, 1, 1, 0, 0, 0, 0, 0, "R2");   // mode pattern under deselect
    cyc(0, 1, 0, 0, 0, 0, 0, 0, "R2");   // mode pattern with cke_prev low
    rd(0, 1, "R10");            // auto-precharge burst on A
    rd(1, 0, "R7");             // code 3 over code 4 (R12 priority)
    act(0, "R9");               // bank in burst: code 5
    nop("R10");
    act(0, "R9");               // bank recovering: code 6
    nop("R10");
    nop("R10");
    act(0, "R10");              // recovery over: legal
    act(1, "R3");
    pre(0, 1, "R4");            // both close
    nop("R4");
    act(0, "R3");
    wr(0, 1, "R10");
    stop("R10");                // burst stop cuts the burst
    act(0, "R9");
    nop("R10"); nop("R10"); nop("R10");
    stop("R10");                // burst stop with nothing running
    selfr("R1");
    nop("R1");
    bl = 4'd1; tr = 4'd0;
    act(1, "R3");
    rd(1, 1, "R10");            // no burst, no recovery
    act(1, "R10");
    rd(1, 1, "R10");
    nop("R10");
    bl = 4'd2; tr = 4'd1;
    act(0, "R3");
    wr(0, 1, "R10");
    wr(0, 0, "R7");
    nop("R10"); nop("R10");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule